// File: doc/BRIEF.md
# Zero-Turnaround Late-Write SRAM

This block is a synchronous single-port static memory with a small internal array. Each word is made of four 9-bit byte lanes. Read and write commands may follow one another on every clock with no idle cycle between them. This works because write data trails its command by exactly as many cycles as read data does. A static mode input chooses between two datapaths. The registered datapath returns read data one cycle after the command is registered and takes write data two cycles after it. The flow-through datapath returns read data just after the command edge and takes write data one cycle after it.

A command either loads a new external address or continues a four-beat burst that has already started. A burst walks the low two address bits in linear (wrapping add) or interleaved (exclusive-or) order. Writes whose data has not yet arrived sit in a short write queue. A read that hits a queued write sees the newly arriving bytes merged over the stored word. A clock enable freezes the whole pipeline. Output enable and sleep gate the bus drivers without waiting for a clock.

Top module: `zt_sram`

## Requirements
- R1: A load cycle (adv_load = 0) starts an operation only when cs1_n = 0, cs2 = 1 and cs3_n = 0. Any other combination is a deselect: no memory word changes and the bus is not driven for it.
- R2: With mode_flow = 0, a read loaded at enabled edge n drives its data (dq_oe = 1) from just after enabled edge n+1 until the next enabled edge.
- R3: With mode_flow = 0, the data for a write loaded at enabled edge n is taken from dq_in at enabled edge n+2, and at no other edge.
- R4: With mode_flow = 1, a read loaded at enabled edge n drives its data from just after edge n.
- R5: With mode_flow = 1, the data for a write loaded at enabled edge n is taken from dq_in at enabled edge n+1.
- R6: ben_n bit i, active low, enables write of dq bits [9i+8:9i]. A write with ben_n = 4'b1111 changes no memory.
- R7: An edge with clk_en_n = 1 is ignored. A registered read already on the bus keeps driving the same value. A write in progress leaves the bus released, and its data slot moves to the next enabled edge.
- R8: oe_n = 1 or sleep = 1 forces dq_oe = 0 at once, with no clock edge needed.
- R9: With mode_flow = 0, a read loaded on the cycle after a write to the same address returns that write's enabled bytes, taken from dq_in, and the stored bytes elsewhere.
- R10: With lin_burst_n = 0, continue cycles (adv_load = 1) produce low address bits base+1, base+2, base+3, base, modulo 4. The upper bits stay at the base.
- R11: With lin_burst_n = 1, continue cycle k uses low address bits base XOR k, where k counts modulo 4.
- R12: A continue cycle repeats the burst's operation and ignores the chip selects and wr_n. A write continue uses the current ben_n. A continue after a deselect is itself a deselect.
- R13: After reset the bus is released (dq_oe = 0) and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_flow | input | 1 | Static: 1 = flow-through, 0 = registered datapath |
| clk_en_n | input | 1 | Clock enable, active low; high stalls the edge |
| adv_load | input | 1 | 0 = load external address, 1 = continue burst |
| wr_n | input | 1 | 0 = write, 1 = read, on load cycles |
| ben_n | input | NBYTES | Byte write enables, active low |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| addr | input | ADDR_W | Word address |
| lin_burst_n | input | 1 | 0 = linear burst order, 1 = interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous bus release, active high |
| dq_in | input | NBYTES*BYTE_W | Write data from the bus |
| dq_out | output | NBYTES*BYTE_W | Read data to the bus |
| dq_oe | output | 1 | Bus driver enable |

## Verification
Writes and reads are separated by idle cycles, and garbage is placed on dq_in at every edge except the expected data slot. This tells a correct data latency from one that is a cycle off in either mode. A write immediately followed by a read of the same address, with only part of the bytes enabled, separates a working forward path from one that returns stale or fully overwritten words. The same stimulus with the clock enable held high for several edges shows that stalls neither consume the write slot nor drop a read already on the bus. Bursts start from an odd base so that linear and interleaved orders produce different sequences, and the continue cycles carry inactive selects and a low wr_n to show those inputs are ignored.

// File: rtl/zt_pkg.sv
package zt_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;
endpackage

// File: rtl/zt_cmd_ctl.sv
module zt_cmd_ctl
   import zt_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int NBYTES  = 4,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              adv_load,
   input  logic              wr_n,
   input  logic [NBYTES-1:0] ben_n,
   input  logic              cs1_n,
   input  logic              cs2,
   input  logic              cs3_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              lin_burst_n,
   output op_e               s1_op,
   output logic [ADDR_W-1:0] s1_addr,
   output logic [NBYTES-1:0] s1_be
);
   localparam int HI_W = ADDR_W - BURST_W;

   op_e               burst_q, burst_d, op_d;
   logic [ADDR_W-1:0] base_q, base_d, addr_d;
   logic [BURST_W-1:0] cnt_q, cnt_d, low_d;
   logic              selected;

   assign selected = !cs1_n && cs2 && !cs3_n;

   always_comb begin
      burst_d = burst_q;
      base_d  = base_q;
      cnt_d   = cnt_q;
      op_d    = OP_IDLE;
      addr_d  = s1_addr;
      low_d   = '0;
      if (!adv_load) begin
         if (selected) begin
            op_d    = wr_n ? OP_READ : OP_WRITE;
            burst_d = op_d;
            base_d  = addr;
            cnt_d   = '0;
            addr_d  = addr;
         end else begin
            burst_d = OP_IDLE;
         end
      end else if (burst_q != OP_IDLE) begin
         cnt_d  = cnt_q + BURST_W'(1);
         low_d  = lin_burst_n ? (base_q[BURST_W-1:0] ^ cnt_d)
                              : (base_q[BURST_W-1:0] + cnt_d);
         addr_d = {base_q[ADDR_W-1 -: HI_W], low_d};
         op_d   = burst_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         burst_q <= OP_IDLE;
         base_q  <= '0;
         cnt_q   <= '0;
         s1_op   <= OP_IDLE;
         s1_addr <= '0;
         s1_be   <= '0;
      end else if (step) begin
         burst_q <= burst_d;
         base_q  <= base_d;
         cnt_q   <= cnt_d;
         s1_op   <= op_d;
         s1_addr <= addr_d;
         s1_be   <= ~ben_n;
      end
   end
endmodule

// File: rtl/zt_write_queue.sv
module zt_write_queue
   import zt_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int NBYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              mode_flow,
   input  op_e               s1_op,
   input  logic [ADDR_W-1:0] s1_addr,
   input  logic [NBYTES-1:0] s1_be,
   output logic              commit_en,
   output logic [ADDR_W-1:0] commit_addr,
   output logic [NBYTES-1:0] commit_be,
   output logic              fwd_hit,
   output logic [NBYTES-1:0] fwd_be
);
   logic              q_vld;
   logic [ADDR_W-1:0] q_addr;
   logic [NBYTES-1:0] q_be;
   logic              s1_wr;

   assign s1_wr = (s1_op == OP_WRITE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_vld  <= 1'b0;
         q_addr <= '0;
         q_be   <= '0;
      end else if (step) begin
         q_vld  <= s1_wr && !mode_flow;
         q_addr <= s1_addr;
         q_be   <= s1_be;
      end
   end

   always_comb begin
      if (mode_flow) begin
         commit_en   = s1_wr;
         commit_addr = s1_addr;
         commit_be   = s1_be;
      end else begin
         commit_en   = q_vld;
         commit_addr = q_addr;
         commit_be   = q_be;
      end
   end

   assign fwd_hit = !mode_flow && q_vld && (s1_op == OP_READ) && (q_addr == s1_addr);
   assign fwd_be  = q_be;
endmodule

// File: rtl/zt_mem_array.sv
module zt_mem_array #(
   parameter int ADDR_W = 6,
   parameter int NBYTES = 4,
   parameter int BYTE_W = 9
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [ADDR_W-1:0]        waddr,
   input  logic [NBYTES-1:0]        wbe,
   input  logic [NBYTES*BYTE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]        raddr,
   output logic [NBYTES*BYTE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < NBYTES; g++) begin : g_lane
      logic [BYTE_W-1:0] lane_mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we && wbe[g]) lane_mem[waddr] <= wdata[g*BYTE_W +: BYTE_W];
      end

      assign rdata[g*BYTE_W +: BYTE_W] = lane_mem[raddr];
   end
endmodule

// File: rtl/zt_read_out.sv
module zt_read_out #(
   parameter int NBYTES = 4,
   parameter int BYTE_W = 9
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     step,
   input  logic                     mode_flow,
   input  logic                     s1_is_rd,
   input  logic [NBYTES*BYTE_W-1:0] arr_data,
   input  logic                     fwd_hit,
   input  logic [NBYTES-1:0]        fwd_be,
   input  logic [NBYTES*BYTE_W-1:0] fwd_data,
   output logic [NBYTES*BYTE_W-1:0] dout,
   output logic                     drive
);
   localparam int DATA_W = NBYTES * BYTE_W;

   logic [DATA_W-1:0] merged, oreg;
   logic              ovalid;

   for (genvar g = 0; g < NBYTES; g++) begin : g_merge
      assign merged[g*BYTE_W +: BYTE_W] = (fwd_hit && fwd_be[g])
                                          ? fwd_data[g*BYTE_W +: BYTE_W]
                                          : arr_data[g*BYTE_W +: BYTE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oreg   <= '0;
         ovalid <= 1'b0;
      end else if (step) begin
         oreg   <= merged;
         ovalid <= s1_is_rd && !mode_flow;
      end
   end

   assign dout  = mode_flow ? arr_data : oreg;
   assign drive = mode_flow ? s1_is_rd : ovalid;
endmodule

// File: rtl/zt_sram.sv
module zt_sram
   import zt_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int NBYTES  = 4,
   parameter int BYTE_W  = 9,
   parameter int BURST_W = 2,
   localparam int DATA_W = NBYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_flow,
   input  logic              clk_en_n,
   input  logic              adv_load,
   input  logic              wr_n,
   input  logic [NBYTES-1:0] ben_n,
   input  logic              cs1_n,
   input  logic              cs2,
   input  logic              cs3_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              lin_burst_n,
   input  logic              oe_n,
   input  logic              sleep,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);
   initial begin
      assert (ADDR_W > BURST_W) else $error("ADDR_W must exceed BURST_W");
      assert (BURST_W >= 1)     else $error("BURST_W must be at least 1");
      assert (NBYTES >= 1)      else $error("NBYTES must be at least 1");
      assert (BYTE_W >= 1)      else $error("BYTE_W must be at least 1");
   end

   logic              step;
   op_e               s1_op;
   logic [ADDR_W-1:0] s1_addr;
   logic [NBYTES-1:0] s1_be;
   logic              commit_en, fwd_hit, rd_drive;
   logic [ADDR_W-1:0] commit_addr;
   logic [NBYTES-1:0] commit_be, fwd_be;
   logic [DATA_W-1:0] arr_data;

   assign step = !clk_en_n;

   zt_cmd_ctl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BURST_W(BURST_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .step(step), .adv_load(adv_load), .wr_n(wr_n),
      .ben_n(ben_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .addr(addr),
      .lin_burst_n(lin_burst_n), .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be)
   );

   zt_write_queue #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_wq (
      .clk(clk), .rst_n(rst_n), .step(step), .mode_flow(mode_flow),
      .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be),
      .commit_en(commit_en), .commit_addr(commit_addr), .commit_be(commit_be),
      .fwd_hit(fwd_hit), .fwd_be(fwd_be)
   );

   zt_mem_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_mem (
      .clk(clk), .we(step && commit_en), .waddr(commit_addr), .wbe(commit_be),
      .wdata(dq_in), .raddr(s1_addr), .rdata(arr_data)
   );

   zt_read_out #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_out (
      .clk(clk), .rst_n(rst_n), .step(step), .mode_flow(mode_flow),
      .s1_is_rd(s1_op == OP_READ), .arr_data(arr_data), .fwd_hit(fwd_hit),
      .fwd_be(fwd_be), .fwd_data(dq_in), .dout(dq_out), .drive(rd_drive)
   );

   assign dq_oe = rd_drive && !oe_n && !sleep;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
   parameter int DATA_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_flow,
   input logic              clk_en_n,
   input logic              adv_load,
   input logic              wr_n,
   input logic              cs1_n,
   input logic              cs2,
   input logic              cs3_n,
   input logic              sleep,
   input logic [DATA_W-1:0] dq_out,
   input logic              rd_drive,
   input logic              dq_oe
);
   logic sel_ok, rd_load;
   assign sel_ok  = !cs1_n && cs2 && !cs3_n;
   assign rd_load = !adv_load && sel_ok && wr_n;

   // R4: flow-through read is on the bus right after its edge
   a_r4_flow_read_now: assert property (@(posedge clk) disable iff (!rst_n)
      mode_flow && !clk_en_n && rd_load |=> rd_drive);

   // R2: registered read appears after the following enabled edge
   a_r2_pipe_read_late: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_flow && !clk_en_n && rd_load ##1 !clk_en_n |=> rd_drive);

   // R1: deselected load never drives in flow-through mode
   a_r1_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      mode_flow && !clk_en_n && !adv_load && !sel_ok |=> !rd_drive);

   // R7: a stalled edge changes neither the data nor the drive
   a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> $stable(dq_out) && $stable(rd_drive));

   // R8: sleep releases the bus
   a_r8_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !dq_oe);
endmodule

bind zt_sram zt_sram_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_flow(mode_flow), .clk_en_n(clk_en_n),
   .adv_load(adv_load), .wr_n(wr_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
   .sleep(sleep), .dq_out(dq_out), .rd_drive(rd_drive), .dq_oe(dq_oe)
);

// File: tb/sim_zt_sram.sv
module sim_zt_sram;
   localparam int CLK_P  = 10;
   localparam int ADDR_W = 6;
   localparam int NB     = 4;
   localparam int DW     = 36;

   logic clk = 1'b0;
   logic rst_n, mode_flow, clk_en_n, adv_load, wr_n, cs1_n, cs2, cs3_n;
   logic lin_burst_n, oe_n, sleep, dq_oe;
   logic [NB-1:0]     ben_n;
   logic [ADDR_W-1:0] addr;
   logic [DW-1:0]     dq_in, dq_out;

   int checks = 0, errors = 0;
   bit done = 0;

   localparam logic [DW-1:0] GARB = 36'hF_0F0F_0F0F;
   localparam logic [DW-1:0] D1 = 36'h1_2345_6789, D2 = 36'hA_BCDE_F012;
   localparam logic [DW-1:0] D3 = 36'h5_5555_5555, D4 = 36'h3_1415_9265;
   localparam logic [DW-1:0] D5 = 36'h2_7182_8182, D6 = 36'h9_8765_4321;
   localparam logic [DW-1:0] D7 = 36'hE_EEEE_EEEE, D8 = 36'h0_CAFE_BEEF;
   localparam logic [DW-1:0] D9 = 36'h7_0000_ABCD;
   localparam logic [DW-1:0] V0 = 36'h1_1111_1111, V1 = 36'h2_2222_2222;
   localparam logic [DW-1:0] V2 = 36'h3_3333_3333, V3 = 36'h4_4444_4444;

   always #(CLK_P/2) clk = ~clk;

   zt_sram u0 (
      .clk(clk), .rst_n(rst_n), .mode_flow(mode_flow), .clk_en_n(clk_en_n),
      .adv_load(adv_load), .wr_n(wr_n), .ben_n(ben_n), .cs1_n(cs1_n), .cs2(cs2),
      .cs3_n(cs3_n), .addr(addr), .lin_burst_n(lin_burst_n), .oe_n(oe_n),
      .sleep(sleep), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic ld(input logic w, input logic [NB-1:0] be, input logic [ADDR_W-1:0] a);
      clk_en_n = 0; adv_load = 0; wr_n = w; ben_n = be; addr = a;
      cs1_n = 0; cs2 = 1; cs3_n = 0;
      tick();
   endtask

   task automatic nop();
      clk_en_n = 0; adv_load = 0; wr_n = 1; ben_n = '1; cs1_n = 1; cs2 = 1; cs3_n = 0;
      tick();
   endtask

   task automatic cont(input logic [NB-1:0] be, input logic c2, input logic w);
      clk_en_n = 0; adv_load = 1; ben_n = be; cs2 = c2; wr_n = w; cs1_n = 0; cs3_n = 0;
      tick();
   endtask

   task automatic do_reset(input logic flow);
      rst_n = 0; mode_flow = flow; clk_en_n = 0; adv_load = 0; wr_n = 1; ben_n = '1;
      cs1_n = 1; cs2 = 1; cs3_n = 0; addr = '0; lin_burst_n = 0; oe_n = 0; sleep = 0;
      dq_in = GARB;
      tick(); tick();
      rst_n = 1;
      tick();
      chk("R13 bus released after reset", {35'd0, dq_oe}, 36'd0);
   endtask

   task automatic t_pipe_basic();
      dq_in = GARB; ld(0, 4'b0000, 6'd5);
      dq_in = GARB; nop();
      dq_in = D1;   nop();
      dq_in = GARB; ld(1, 4'b1111, 6'd5);
      chk("R2 not yet driven after command edge", {35'd0, dq_oe}, 36'd0);
      nop();
      chk("R2 driven one edge later", {35'd0, dq_oe}, 36'd1);
      chk("R3 data from second edge after write", dq_out, D1);
      nop();
      chk("R2 bus released after read slot", {35'd0, dq_oe}, 36'd0);
   endtask

   task automatic t_bytes();
      dq_in = GARB; ld(0, 4'b1010, 6'd5);
      nop();
      dq_in = D2; nop();
      dq_in = GARB; ld(0, 4'b1111, 6'd5);
      nop();
      dq_in = D3; nop();
      dq_in = GARB; ld(1, 4'b1111, 6'd5);
      nop();
      chk("R6 byte lanes and write abort",
          dq_out, {D1[35:27], D2[26:18], D1[17:9], D2[8:0]});
   endtask

   task automatic t_forward();
      dq_in = GARB; ld(0, 4'b0000, 6'd9);
      nop();
      dq_in = D4; nop();
      dq_in = GARB; ld(0, 4'b0011, 6'd9);
      ld(1, 4'b1111, 6'd9);
      dq_in = D5; nop();
      chk("R9 forwarded read drives", {35'd0, dq_oe}, 36'd1);
      chk("R9 forwarded bytes merged", dq_out, {D5[35:18], D4[17:0]});
      dq_in = GARB; nop();
   endtask

   task automatic t_stall();
      ld(1, 4'b1111, 6'd9);
      nop();
      for (int i = 0; i < 3; i++) begin
         clk_en_n = 1; adv_load = 0; wr_n = 0; cs1_n = 0; addr = 6'd12;
         tick();
         chk("R7 stalled read keeps driving", {35'd0, dq_oe}, 36'd1);
         chk("R7 stalled read keeps data", dq_out, {D5[35:18], D4[17:0]});
      end
      dq_in = GARB; ld(0, 4'b0000, 6'd12);
      nop();
      chk("R7 write cycle leaves bus released", {35'd0, dq_oe}, 36'd0);
      for (int i = 0; i < 2; i++) begin
         clk_en_n = 1; dq_in = GARB;
         tick();
         chk("R7 stalled write stays released", {35'd0, dq_oe}, 36'd0);
      end
      dq_in = D6; nop();
      dq_in = GARB; ld(1, 4'b1111, 6'd12);
      nop();
      chk("R7 write slot moved past stalls", dq_out, D6);
   endtask

   task automatic t_oe_sleep();
      ld(1, 4'b1111, 6'd12);
      nop();
      chk("R8 driven with oe_n low", {35'd0, dq_oe}, 36'd1);
      oe_n = 1; #1;
      chk("R8 oe_n high releases at once", {35'd0, dq_oe}, 36'd0);
      oe_n = 0; #1;
      chk("R8 oe_n low drives again", {35'd0, dq_oe}, 36'd1);
      sleep = 1; #1;
      chk("R8 sleep releases at once", {35'd0, dq_oe}, 36'd0);
      sleep = 0;
      nop();
   endtask

   task automatic t_deselect();
      dq_in = GARB; ld(0, 4'b0000, 6'd20);
      nop();
      dq_in = D8; nop();
      dq_in = D7;
      for (int i = 0; i < 3; i++) begin
         clk_en_n = 0; adv_load = 0; wr_n = 0; ben_n = '0; addr = 6'd20;
         cs1_n = (i == 0); cs2 = (i != 1); cs3_n = (i == 2);
         tick();
      end
      nop(); nop();
      dq_in = GARB; ld(1, 4'b1111, 6'd20);
      nop();
      chk("R1 deselected writes left word intact", dq_out, D8);
      clk_en_n = 0; adv_load = 0; wr_n = 1; addr = 6'd20; cs1_n = 0; cs2 = 1; cs3_n = 1;
      tick();
      nop();
      chk("R1 deselected read not driven", {35'd0, dq_oe}, 36'd0);
   endtask

   task automatic t_flow_basic();
      dq_in = GARB; ld(0, 4'b0000, 6'd30);
      dq_in = D9;   nop();
      dq_in = GARB; ld(1, 4'b1111, 6'd30);
      chk("R4 flow read drives after its own edge", {35'd0, dq_oe}, 36'd1);
      chk("R5 flow write data from next edge", dq_out, D9);
      nop();
      chk("R4 flow bus released after read", {35'd0, dq_oe}, 36'd0);
   endtask

   task automatic t_burst();
      lin_burst_n = 0;
      dq_in = GARB; ld(0, 4'b0000, 6'd5);
      dq_in = V0; cont(4'b0000, 1, 0);
      dq_in = V1; cont(4'b0000, 1, 0);
      dq_in = V2; cont(4'b0000, 1, 0);
      dq_in = V3; nop();
      dq_in = GARB;
      ld(1, 4'b1111, 6'd4);
      chk("R10 linear burst wrapped to low bits 0", dq_out, V3);
      ld(1, 4'b1111, 6'd7);
      chk("R10 linear burst third beat", dq_out, V2);
      lin_burst_n = 1;
      ld(1, 4'b1111, 6'd5);
      chk("R11 interleaved beat 0", dq_out, V0);
      cont(4'b1111, 0, 0);
      chk("R12 continue ignores selects and wr_n", {35'd0, dq_oe}, 36'd1);
      chk("R11 interleaved beat 1", dq_out, V3);
      cont(4'b1111, 0, 0);
      chk("R11 interleaved beat 2", dq_out, V2);
      cont(4'b1111, 0, 0);
      chk("R11 interleaved beat 3", dq_out, V1);
      cont(4'b1111, 0, 0);
      chk("R11 interleaved wraps to base", dq_out, V0);
      nop();
      cont(4'b1111, 1, 1);
      chk("R12 continue after deselect not driven", {35'd0, dq_oe}, 36'd0);
   endtask

   initial begin
      do_reset(0);
      t_pipe_basic();
      t_bytes();
      t_forward();
      t_stall();
      t_oe_sleep();
      t_deselect();
      do_reset(1);
      t_flow_basic();
      t_burst();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule